// File: doc/BRIEF.md
# Sleep-Forced Pin Mode Resolver

This block picks, for every pin of a bank, who drives the pad. Each pin can be under GPIO control (its data, direction and pull settings) or under one of three peripheral functions, named alternates A, B and C. Two select planes, one bit per pin each, give the normal choice. A single global force input, raised by the platform when it enters a low-power state, can override that choice. The override only applies to pins that have opted in.

Opt-in comes from a per-pin keep plane. A keep bit of 0 marks a pin for override. While force is high, such a pin is taken back to GPIO control and its wake detection is armed. A keep bit of 1 leaves the pin in its normal mode during force, with wake detection off. When force drops, every pin returns to the mode its select bits give. The resolved two-bit mode per pin and the wake-enable mask come out of a register stage. The pad multiplexer and the register bus that holds the planes sit outside this block, so the planes arrive here as plain inputs. After reset the keep plane is expected to read all ones, which means no pin is overridden.

Top module: `pin_mode_resolver`

## Requirements
- R1: With force low, the mode of pin i is {sel_b[i], sel_a[i]}, encoded 2'b00 GPIO, 2'b01 alternate A, 2'b10 alternate B, 2'b11 alternate C. It occupies bits pin_mode[2*i+1:2*i].
- R2: With force high and keep[i] = 0, the mode of pin i is 2'b00 (GPIO), whatever its select bits are.
- R3: With force high and keep[i] = 0, wake_en[i] is 1.
- R4: With force high and keep[i] = 1, the mode of pin i follows its select bits as in R1, and wake_en[i] is 0.
- R5: With force low, wake_en is 0 for every pin whatever the keep plane holds, and every pin reverts to its select-bit mode.
- R6: Both outputs are registered. A change on any input shows at the outputs after the next rising clock edge and not before it.
- R7: While reset (rst_n low, asynchronous) is asserted, every pin reads mode 2'b00 and wake_en reads all zeros.
- R8: Pins resolve independently. In one cycle, forced, kept and unforced pins with different selects each follow their own rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | NUM_PINS | Low select bit per pin |
| sel_b | input | NUM_PINS | High select bit per pin |
| keep | input | NUM_PINS | Sleep keep plane; 0 = override to GPIO and arm wake while forced |
| force_i | input | 1 | Global sleep force |
| pin_mode | output | 2*NUM_PINS | Resolved mode, two bits per pin, pin 0 in the low bits |
| wake_en | output | NUM_PINS | Per-pin wake-detection enable |

## Verification
Both results, mode and wake mask, are due one rising edge after the inputs that produce them. The bench changes inputs on the falling edge and samples on the following falling edge, one edge later. One directed check samples before that edge and expects the old values, which shows the stage is not bypassed. Reset is checked while rst_n is still low, with inputs that would otherwise force nonzero outputs.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      PM_GPIO  = 2'b00,
      PM_ALT_A = 2'b01,
      PM_ALT_B = 2'b10,
      PM_ALT_C = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/pmr_pin_cell.sv
module pmr_pin_cell
   import pmr_pkg::*;
(
   input  logic      sel_a,
   input  logic      sel_b,
   input  logic      keep,
   input  logic      force_i,
   output pin_mode_e mode,
   output logic      wake
);
   logic override;

   // a cleared keep bit opts the pin into override, but only while forced
   assign override = force_i && !keep;

   always_comb begin
      if (override) mode = PM_GPIO;
      else          mode = pin_mode_e'({sel_b, sel_a});
   end

   assign wake = override;
endmodule

// File: rtl/pmr_out_stage.sv
module pmr_out_stage #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (WIDTH < 1) $error("pmr_out_stage: WIDTH must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/pin_mode_resolver.sv
module pin_mode_resolver
   import pmr_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        sel_a,
   input  logic [NUM_PINS-1:0]        sel_b,
   input  logic [NUM_PINS-1:0]        keep,
   input  logic                       force_i,
   output logic [MODE_W*NUM_PINS-1:0] pin_mode,
   output logic [NUM_PINS-1:0]        wake_en
);
   localparam int MODE_BITS = MODE_W * NUM_PINS;
   localparam int STAGE_W   = MODE_BITS + NUM_PINS;

   initial begin
      if (NUM_PINS < 1 || NUM_PINS > 64)
         $error("pin_mode_resolver: NUM_PINS must be 1..64");
   end

   logic [MODE_BITS-1:0] mode_nxt;
   logic [NUM_PINS-1:0]  wake_nxt;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pin_mode_e cell_mode;

      pmr_pin_cell u_cell (
         .sel_a   (sel_a[i]),
         .sel_b   (sel_b[i]),
         .keep    (keep[i]),
         .force_i (force_i),
         .mode    (cell_mode),
         .wake    (wake_nxt[i])
      );

      assign mode_nxt[MODE_W*i +: MODE_W] = cell_mode;

      // R2: an opted-in pin under force lands in GPIO one edge later
      p_forced_gpio_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (force_i && !keep[i]) |=> (pin_mode[MODE_W*i +: MODE_W] == 2'b00));

      // R3: wake armed only for forced, opted-in pins
      p_wake_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
         wake_en[i] |-> ($past(force_i) && !$past(keep[i])));

      // R4: a kept pin holds its select mode with wake off under force
      p_kept_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (force_i && keep[i]) |=>
            (pin_mode[MODE_W*i +: MODE_W] == {$past(sel_b[i]), $past(sel_a[i])})
            && !wake_en[i]);

      // R1 / R5: unforced pins follow the select planes
      p_unforced_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !force_i |=>
            (pin_mode[MODE_W*i +: MODE_W] == {$past(sel_b[i]), $past(sel_a[i])}));
   end

   // R5: no wake anywhere while force is low
   p_no_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !force_i |=> (wake_en == '0));

   pmr_out_stage #(.WIDTH(STAGE_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({wake_nxt, mode_nxt}),
      .q     ({wake_en, pin_mode})
   );
endmodule

// File: tb/pin_mode_resolver_tb.sv
module pin_mode_resolver_tb;
   localparam int N  = 32;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  sel_a = '0, sel_b = '0, keep = '1;
   logic          force_i = 1'b0;
   logic [2*N-1:0] pin_mode;
   logic [N-1:0]  wake_en;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   pin_mode_resolver #(.NUM_PINS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
      .keep(keep), .force_i(force_i), .pin_mode(pin_mode), .wake_en(wake_en)
   );

   // stimulus table: sel_a, sel_b, keep, force, requirement tag
   localparam logic [N-1:0] T_A [NV] = '{32'h5555_5555, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                         32'hF0F0_A5A5, 32'h1234_5678, 32'h1234_5678, 32'hDEAD_BEEF};
   localparam logic [N-1:0] T_B [NV] = '{32'h3333_3333, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                         32'hCCCC_3C3C, 32'h8765_4321, 32'h8765_4321, 32'hCAFE_F00D};
   localparam logic [N-1:0] T_K [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF,
                                         32'h00FF_0F0F, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'h0F0F_F0F0};
   localparam logic       T_F [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
   localparam string      T_R [NV] = '{"R1/R5", "R4", "R2/R3", "R4", "R8", "R8", "R5", "R8"};

   function automatic logic [2*N-1:0] want_mode(logic [N-1:0] a, logic [N-1:0] b,
                                                logic [N-1:0] k, logic f);
      logic [2*N-1:0] m;
      for (int i = 0; i < N; i++)
         m[2*i +: 2] = (f && !k[i]) ? 2'b00 : {b[i], a[i]};
      return m;
   endfunction

   function automatic logic [N-1:0] want_wake(logic [N-1:0] k, logic f);
      return f ? ~k : '0;
   endfunction

   task automatic check(string req, logic [2*N-1:0] em, logic [N-1:0] ew);
      total++;
      if (pin_mode !== em || wake_en !== ew) begin
         bad++;
         $display("FAIL %s: mode=%h wake=%h expected mode=%h wake=%h",
                  req, pin_mode, wake_en, em, ew);
      end
   endtask

   task automatic apply(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] k, logic f);
      @(negedge clk);
      sel_a = a; sel_b = b; keep = k; force_i = f;
   endtask

   initial begin
      #(8 * 20000);
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R7: reset holds outputs at zero even with forcing inputs present
      sel_a = '1; sel_b = '1; keep = '0; force_i = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 reset", '0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 first edge after reset", want_mode('1, '1, '0, 1'b1), '1);

      // table walk
      for (int v = 0; v < NV; v++) begin
         apply(T_A[v], T_B[v], T_K[v], T_F[v]);
         @(negedge clk);
         check(T_R[v], want_mode(T_A[v], T_B[v], T_K[v], T_F[v]), want_wake(T_K[v], T_F[v]));
      end

      // R1: each encoding on a single pin, force low
      begin
         logic [N-1:0] a1, b1;
         a1 = 32'h0000_000A; b1 = 32'h0000_000C;
         apply(a1, b1, '1, 1'b0);
         @(negedge clk);
         check("R1 encodings", {56'h0, 8'b11_10_01_00}, '0);
      end

      // R6: output must not move before the edge
      apply('1, '0, '1, 1'b0);
      @(negedge clk);
      check("R6 settle", want_mode('1, '0, '1, 1'b0), '0);
      @(negedge clk);
      sel_a = '0; sel_b = '1; keep = '0; force_i = 1'b1;
      #1;
      check("R6 no bypass", want_mode('1, '0, '1, 1'b0), '0);
      @(negedge clk);
      check("R6 after edge", '0, '1);

      // R5: force drop reverts everything
      apply('0, '1, '0, 1'b0);
      @(negedge clk);
      check("R5 revert", want_mode('0, '1, '0, 1'b0), '0);

      // R7: asynchronous reset mid-run
      apply('1, '1, '1, 1'b0);
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1 check("R7 async reset", '0, '0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule